// File: doc/BRIEF.md
# Trimmed Real-Time Seconds Counter

This block keeps wall-clock time in whole seconds. It runs on the system clock and receives a one-cycle enable, `xtal_tick`, for each period of a nominal 32.768 kHz crystal. A prescaler divides those crystal periods down to a nominal 1 Hz second tick. The divide ratio is programmable. A second programmable value lets the prescaler skip a fixed number of crystal periods once per long trim cycle, which corrects for a crystal that runs slightly fast.

Each second tick advances a 32-bit seconds counter. The counter is compared against an alarm value. Two sticky event flags, one for the alarm and one for the second tick, each drive an interrupt output through their own enable bit. Software uses a small word-addressed register bus to read and write the alarm value, the counter, the trim setting and the status.

With divide count C and skip count D, the average tick rate is the crystal rate × (1023·(C+1) − D) / (1023·(C+1)²) to first order. The length of the trim cycle is the parameter `TRIM_PERIOD`, with a default of 1023.

Top module: `rtc_trim_top`

## Requirements
- R1: After reset the alarm value and the counter read 0, the trim register reads C=0x7FFF and D=0, the status reads 0, and both interrupt outputs are low.
- R2: With D=0 the prescaler issues one second tick for every C+1 cycles in which `xtal_tick` is high. Clock cycles without `xtal_tick` do not advance the prescaler or the counter.
- R3: Counting from a write to the trim register, the k-th second tick (k ≥ 1) falls on crystal tick number k·(C+1) + floor((k−1)/TRIM_PERIOD)·D. After every TRIM_PERIOD-th tick, the next D crystal ticks are ignored. A write to the trim register restarts the prescaler from zero.
- R4: The counter increments by one on each second tick and wraps from 0xFFFFFFFF to 0. A bus write loads the counter. A bus write in the same cycle as a tick takes priority over the tick.
- R5: Status bit 0 (the alarm flag) is set when a tick increments the counter to a value equal to the alarm value. Loading the counter or the alarm value by a bus write never sets the flag.
- R6: Status bit 1 (the second flag) is set on every second tick.
- R7: Both flags are sticky. Writing 1 to a flag's bit clears it, and writing 0 leaves it unchanged. If a set and a clear arrive in the same cycle, the set wins. Status bits 2 (alarm enable) and 3 (second enable) are plain read/write bits.
- R8: `irq_alarm` is status bit 0 AND bit 2. `irq_sec` is status bit 1 AND bit 3.
- R9: Byte offsets: 0x00 is the alarm value, 0x04 the counter, 0x08 the trim register (bits [15:0] = C, bits [25:16] = D) and 0x10 the status. Reserved bits read 0. Any other offset reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_tick | input | 1 | One-cycle enable per crystal period |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, with bus_en |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_sec | output | 1 | Second-tick interrupt |

## Verification
The assertions assume the following about the inputs:
- `xtal_tick` lasts exactly one clock cycle.
- Bus accesses are single-cycle strobes with the offset stable while `bus_en` is high.
- The trim register is written before C is relied on, so the prescaler divide counter never starts above C.

The stimulus keeps to these assumptions. Every access and every crystal pulse is issued on a falling edge and lasts one cycle. Each trim setting is applied by a bus write, which restarts the prescaler, before any crystal pulses are applied.

The bench uses a trim cycle of 4 ticks so that the skip happens many times in a short run. It compares the counter after every crystal pulse against a closed-form count of the ticks due by that point.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  localparam logic [4:0] OFS_ALARM  = 5'h00;
  localparam logic [4:0] OFS_COUNT  = 5'h04;
  localparam logic [4:0] OFS_TRIM   = 5'h08;
  localparam logic [4:0] OFS_STATUS = 5'h10;

  // bit order matches the status register: [3]=sec_en [2]=alarm_en [1]=sec [0]=alarm
  typedef struct packed {
    logic sec_en;
    logic alarm_en;
    logic sec;
    logic alarm;
  } rtc_status_t;

  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W       = 16,
  parameter int DEL_W       = 10,
  parameter int TRIM_PERIOD = 1023
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtal_tick,
  input  logic             reload,
  input  logic [DIV_W-1:0] div_limit,
  input  logic [DEL_W-1:0] del_count,
  output logic             sec_tick
);
  localparam int PER_W = $clog2(TRIM_PERIOD + 1);
  localparam logic [PER_W-1:0] PER_LAST = PER_W'(TRIM_PERIOD - 1);

  logic [DIV_W-1:0] div_cnt;
  logic [PER_W-1:0] per_cnt;
  logic [DEL_W-1:0] del_left;
  logic             deleting;
  logic             div_wrap;
  logic             trim_point;

  assign deleting   = (del_left != '0);
  assign div_wrap   = (div_cnt == div_limit);
  assign sec_tick   = xtal_tick && !reload && !deleting && div_wrap;
  assign trim_point = sec_tick && (per_cnt == PER_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      per_cnt  <= '0;
      del_left <= '0;
    end else if (reload) begin
      div_cnt  <= '0;
      per_cnt  <= '0;
      del_left <= '0;
    end else if (xtal_tick) begin
      if (deleting) begin
        del_left <= del_left - DEL_W'(1);
      end else if (div_wrap) begin
        div_cnt <= '0;
        if (trim_point) begin
          per_cnt  <= '0;
          del_left <= del_count;
        end else begin
          per_cnt <= per_cnt + PER_W'(1);
        end
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!xtal_tick && !reload) |=> ($stable(div_cnt) && $stable(del_left) && $stable(per_cnt)));
  assert_tick_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> (div_cnt == '0));
  assert_skip_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trim_point |=> (del_left == $past(del_count)));
  assert_reload_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (div_cnt == '0 && del_left == '0 && per_cnt == '0));
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] alarm_val,
  output logic [CNT_W-1:0] count,
  output logic             alarm_hit
);
  function automatic logic [CNT_W-1:0] step(logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] count_inc;
  assign count_inc = step(count);
  assign alarm_hit = sec_tick && !load && (count_inc == alarm_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (load)     count <= load_val;
    else if (sec_tick) count <= count_inc;
  end

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !load) |=> (count == $past(count) + CNT_W'(1)));
  assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));
  assert_alarm_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> (count == $past(alarm_val)));
endmodule

// File: rtl/rtc_status.sv
module rtc_status
  import rtc_trim_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_alarm,
  input  logic        set_sec,
  input  logic        wr,
  input  logic [3:0]  wdata,
  output rtc_status_t status,
  output logic        irq_alarm,
  output logic        irq_sec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
    end else begin
      status.alarm <= sticky_next(status.alarm, set_alarm, wr & wdata[0]);
      status.sec   <= sticky_next(status.sec,   set_sec,   wr & wdata[1]);
      if (wr) begin
        status.alarm_en <= wdata[2];
        status.sec_en   <= wdata[3];
      end
    end
  end

  assign irq_alarm = status.alarm & status.alarm_en;
  assign irq_sec   = status.sec   & status.sec_en;

  assert_alarm_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status.alarm && !(wr && wdata[0])) |=> status.alarm);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_sec |=> status.sec);
  assert_alarm_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_alarm) |-> status.alarm_en);
  assert_sec_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_sec) |-> status.sec_en);
endmodule

// File: rtl/rtc_trim_top.sv
module rtc_trim_top
  import rtc_trim_pkg::*;
#(
  parameter int               DIV_W       = 16,
  parameter int               DEL_W       = 10,
  parameter int               TRIM_PERIOD = 1023,
  parameter logic [DIV_W-1:0] DIV_RESET   = 16'h7FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xtal_tick,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_alarm,
  output logic        irq_sec
);
  localparam int CNT_W = 32;
  localparam int PAD_W = CNT_W - DIV_W - DEL_W;

  logic             wr;
  logic             wr_alarm, wr_count, wr_trim, wr_status;
  logic [CNT_W-1:0] alarm_reg;
  logic [DIV_W-1:0] div_limit;
  logic [DEL_W-1:0] del_count;
  logic [CNT_W-1:0] count;
  logic             sec_tick;
  logic             alarm_hit;
  rtc_status_t      status;

  assign wr        = bus_en & bus_we;
  assign wr_alarm  = wr && (bus_addr == OFS_ALARM);
  assign wr_count  = wr && (bus_addr == OFS_COUNT);
  assign wr_trim   = wr && (bus_addr == OFS_TRIM);
  assign wr_status = wr && (bus_addr == OFS_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_reg <= '0;
      div_limit <= DIV_RESET;
      del_count <= '0;
    end else begin
      if (wr_alarm) alarm_reg <= bus_wdata;
      if (wr_trim) begin
        div_limit <= bus_wdata[DIV_W-1:0];
        del_count <= bus_wdata[DIV_W +: DEL_W];
      end
    end
  end

  rtc_prescaler #(.DIV_W(DIV_W), .DEL_W(DEL_W), .TRIM_PERIOD(TRIM_PERIOD)) presc_i (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .reload(wr_trim),
    .div_limit(div_limit), .del_count(del_count), .sec_tick(sec_tick)
  );

  rtc_seconds #(.CNT_W(CNT_W)) secs_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .load(wr_count),
    .load_val(bus_wdata), .alarm_val(alarm_reg), .count(count), .alarm_hit(alarm_hit)
  );

  rtc_status stat_i (
    .clk(clk), .rst_n(rst_n), .set_alarm(alarm_hit), .set_sec(sec_tick),
    .wr(wr_status), .wdata(bus_wdata[3:0]), .status(status),
    .irq_alarm(irq_alarm), .irq_sec(irq_sec)
  );

  always_comb begin
    case (bus_addr)
      OFS_ALARM:  bus_rdata = alarm_reg;
      OFS_COUNT:  bus_rdata = count;
      OFS_TRIM:   bus_rdata = {{PAD_W{1'b0}}, del_count, div_limit};
      OFS_STATUS: bus_rdata = {28'b0, status};
      default:    bus_rdata = '0;
    endcase
  end

  assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !(wr_alarm || wr_count || wr_trim || wr_status)) |=>
      ($stable(alarm_reg) && $stable(div_limit) && $stable(del_count)));
endmodule

// File: tb/rtc_trim_top_tb.sv
`timescale 1ns/1ps
module rtc_trim_top_tb_top;
  localparam int TP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xtal_tick = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = 5'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_alarm, irq_sec;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_trim_top #(.TRIM_PERIOD(TP)) dut_i (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_alarm(irq_alarm), .irq_sec(irq_sec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic xtal();
    @(negedge clk);
    xtal_tick = 1'b1;
    @(negedge clk);
    xtal_tick = 1'b0;
  endtask

  // ticks due after n crystal ticks: tick k falls at k(C+1) + floor((k-1)/TP)*D
  function automatic int due(input int n, input int c, input int d);
    int k = 1;
    int cnt = 0;
    while (k * (c + 1) + ((k - 1) / TP) * d <= n) begin
      cnt++;
      k++;
    end
    return cnt;
  endfunction

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h00, v); chk("R1 alarm", v, 32'h0);
    rd(5'h04, v); chk("R1 count", v, 32'h0);
    rd(5'h08, v); chk("R1 trim", v, 32'h0000_7FFF);
    rd(5'h10, v); chk("R1 status", v, 32'h0);
    chk("R1 irqs", {30'b0, irq_alarm, irq_sec}, 32'h0);

    // R9 unmapped offset: reads zero, write has no effect
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, v); chk("R9 unmapped read", v, 32'h0);
    rd(5'h00, v); chk("R9 alarm untouched", v, 32'h0);
    rd(5'h08, v); chk("R9 trim untouched", v, 32'h0000_7FFF);
    rd(5'h10, v); chk("R9 status untouched", v, 32'h0);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, v); chk("R9 trim reserved bits", v, 32'h03FF_FFFF);

    // R2/R3 sweep of divide and skip counts
    for (int c = 0; c < 4; c++) begin
      for (int di = 0; di < 3; di++) begin
        int d;
        d = (di == 0) ? 0 : (di == 1 ? 1 : 3);
        wr(5'h08, (d << 16) | c);
        wr(5'h04, 32'h0);
        for (int n = 1; n <= 30; n++) begin
          xtal();
          rd(5'h04, v);
          chk(d == 0 ? "R2 divide" : "R3 trim skip", v, 32'(due(n, c, d)));
        end
        repeat (5) @(negedge clk);
        rd(5'h04, v);
        chk("R2 idle hold", v, 32'(due(30, c, d)));
      end
    end

    // divide by one for the event tests
    wr(5'h08, 32'h0);
    wr(5'h10, 32'h3);
    rd(5'h10, v); chk("R7 w1c clears", v, 32'h0);

    // R6 second flag, R8 irq gating
    xtal();
    rd(5'h10, v); chk("R6 second flag", v, 32'h2);
    chk("R8 irq_sec masked", {31'b0, irq_sec}, 32'h0);
    wr(5'h10, 32'h8);
    rd(5'h10, v); chk("R7 write 0 keeps flag", v, 32'hA);
    chk("R8 irq_sec enabled", {31'b0, irq_sec}, 32'h1);

    // R7 set wins over clear in same cycle
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 5'h10; bus_wdata = 32'h2; xtal_tick = 1'b1;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; xtal_tick = 1'b0;
    rd(5'h10, v); chk("R7 set wins", v, 32'h2);

    // R5 alarm match
    wr(5'h00, 32'd5);
    wr(5'h04, 32'd3);
    wr(5'h10, 32'h3);
    xtal();
    rd(5'h04, v); chk("R4 count 4", v, 32'd4);
    rd(5'h10, v); chk("R5 no alarm before match", v & 32'h1, 32'h0);
    xtal();
    rd(5'h10, v); chk("R5 alarm on match", v & 32'h1, 32'h1);
    chk("R8 irq_alarm masked", {31'b0, irq_alarm}, 32'h0);
    wr(5'h10, 32'h4);
    chk("R8 irq_alarm enabled", {31'b0, irq_alarm}, 32'h1);
    wr(5'h10, 32'h5);
    chk("R8 irq_alarm cleared", {31'b0, irq_alarm}, 32'h0);
    wr(5'h04, 32'd5);
    rd(5'h10, v); chk("R5 load no alarm", v & 32'h1, 32'h0);
    wr(5'h04, 32'd9);
    wr(5'h00, 32'd9);
    rd(5'h10, v); chk("R5 alarm write no alarm", v & 32'h1, 32'h0);

    // R4 wrap and write priority
    wr(5'h00, 32'h0);
    wr(5'h04, 32'hFFFF_FFFF);
    xtal();
    rd(5'h04, v); chk("R4 wrap", v, 32'h0);
    rd(5'h10, v); chk("R5 alarm at wrap", v & 32'h1, 32'h1);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 5'h04; bus_wdata = 32'd100; xtal_tick = 1'b1;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; xtal_tick = 1'b0;
    rd(5'h04, v); chk("R4 write wins", v, 32'd100);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule